// File: doc/BRIEF.md
# UART Interrupt Pending and Mask Unit

This block gathers the four interrupt causes of a serial port into one level-sensitive request line. The four causes are receive data, line error, transmit space and modem event. Each cause sets a sticky pending bit. Software clears a pending bit by writing a one to it. A per-source mask hides individual causes from the output. A separate global enable bit in a control register must also be set before anything reaches the request line.

The block also keeps the line-error status word. A single-cycle strobe from the framer for overrun, parity, frame or break sets the matching flag. Any of these strobes also raises the error pending bit. Reading the status word returns the captured flags and clears them in the same cycle.

Software reaches the block through a simple register port made of a write strobe, a read strobe, an address and write data. Read data is registered: it appears one cycle after the read strobe and holds until the next read.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Pending and mask bits use fixed positions: bit 0 receive, bit 1 error, bit 2 transmit, bit 3 modem. Receive sets while `rx_avail` is 1. Transmit sets while `tx_level <= tx_trig`. Modem sets on a `modem_evt` pulse.
- R2: A write to address 0 clears every pending bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R3: The mask register is at address 0x1, bits [3:0], and reads back what was written. A mask bit of 1 suppresses that source. The mask resets to 4'hF.
- R4: The global enable is bit 0 of address 2. It resets to 0. While it is 0, `irq` is 0.
- R5: `irq` is registered. One cycle after any unmasked pending bit is set with the global enable at 1, `irq` goes to 1, and it stays at 1 as long as that condition holds.
- R6: Pending bits are recorded while masked. Unmasking a pending source raises `irq` on the cycle after the mask write takes effect.
- R7: The error status word at address 3 holds overrun (bit 0), parity (bit 1), frame (bit 2) and break (bit 3). Each flag is sticky once captured. Any capture also sets pending bit 1.
- R8: A read of address 3 returns the flags and clears them. A capture in the same cycle as the read survives the clear.
- R9: When a source sets a pending bit in the same cycle that a write-one-to-clear targets it, the bit ends up set.
- R10: `reg_rdata` updates only on `reg_rd`, one cycle later, zero-extended. Address 0 returns pending, 1 mask, 2 enable, 3 error status, and any other address returns 0. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| rx_avail | input | 1 | Receive data available (level) |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_trig | input | LVL_W | Transmit trigger level |
| modem_evt | input | 1 | Modem event pulse |
| err_ovr | input | 1 | Overrun strobe |
| err_par | input | 1 | Parity error strobe |
| err_frm | input | 1 | Framing error strobe |
| err_brk | input | 1 | Break strobe |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The bench drives a source event and a clear of the same pending bit in one cycle. A design that gives the clear priority would drop the event, and the bit would read back as zero. The bench unmasks a source that became pending while it was hidden. A design that latched only unmasked events would then never raise `irq`. The bench reads the error status word while a new strobe arrives. A clear-on-read that wins over capture would lose that flag, and a design with no clear at all would return stale flags on a second read. Random traffic, with the enable turned off and back on, checks that `irq` follows the gating one cycle late and never early.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC    = 4;
  localparam int SRC_RX  = 0;
  localparam int SRC_ERR = 1;
  localparam int SRC_TX  = 2;
  localparam int SRC_MDM = 3;

  localparam int NERR    = 4;
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;

  localparam int REG_PEND = 0;
  localparam int REG_MASK = 1;
  localparam int REG_CTRL = 2;
  localparam int REG_ERR  = 3;
endpackage

// File: rtl/uirq_pending.sv
module uirq_pending #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           pend_o[k] <= 1'b0;
      else if (set_i[k]) pend_o[k] <= 1'b1;
      else if (clr_i[k]) pend_o[k] <= 1'b0;
    end
  end

  // R2: a clear with no competing set empties the bit
  a_r2_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
  // R9: a set always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/uirq_errstat.sv
module uirq_errstat #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cap_i,
  input  logic         rd_clr_i,
  output logic [N-1:0] flags_o
);
  always_ff @(posedge clk) begin
    if (rst)           flags_o <= '0;
    else if (rd_clr_i) flags_o <= cap_i;
    else               flags_o <= flags_o | cap_i;
  end

  // R8: read clears everything not captured in the same cycle
  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    rd_clr_i |=> ((flags_o & ~$past(cap_i)) == '0));
  // R7: flags stay sticky without a read
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/uirq_out.sv
module uirq_out #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] mask_i,
  input  logic         gie_i,
  output logic         irq_o
);
  logic [N-1:0] live;
  assign live = pend_i & ~mask_i;

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= gie_i & (|live);
  end

  // R4: no request one cycle after the enable is off
  a_r4_gie_gates: assert property (@(posedge clk) disable iff (rst)
    !gie_i |=> !irq_o);
  // R3: fully masked sources never reach the line
  a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    ((pend_i & ~mask_i) == '0) |=> !irq_o);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_avail,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  tx_trig,
  input  logic              modem_evt,
  input  logic              err_ovr,
  input  logic              err_par,
  input  logic              err_frm,
  input  logic              err_brk,
  output logic              irq
);
  localparam int SPARE_W = DATA_W - NSRC;

  logic            sel_pend, sel_mask, sel_ctrl, sel_err;
  logic [NSRC-1:0] src_set, src_clr, pend, mask_q;
  logic [NERR-1:0] err_cap, err_flags;
  logic            gie_q;
  logic [DATA_W-1:0] rd_mux;

  assign sel_pend = (reg_addr == ADDR_W'(REG_PEND));
  assign sel_mask = (reg_addr == ADDR_W'(REG_MASK));
  assign sel_ctrl = (reg_addr == ADDR_W'(REG_CTRL));
  assign sel_err  = (reg_addr == ADDR_W'(REG_ERR));

  always_comb begin
    err_cap          = '0;
    err_cap[ERR_OVR] = err_ovr;
    err_cap[ERR_PAR] = err_par;
    err_cap[ERR_FRM] = err_frm;
    err_cap[ERR_BRK] = err_brk;
  end

  always_comb begin
    src_set          = '0;
    src_set[SRC_RX]  = rx_avail;
    src_set[SRC_ERR] = |err_cap;
    src_set[SRC_TX]  = (tx_level <= tx_trig);
    src_set[SRC_MDM] = modem_evt;
  end

  assign src_clr = (reg_wr && sel_pend) ? reg_wdata[NSRC-1:0] : '0;

  if (SPARE_W > 0) begin : g_spare
    logic unused_wbits;
    assign unused_wbits = ^reg_wdata[DATA_W-1:NSRC];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      gie_q  <= 1'b0;
    end else if (reg_wr) begin
      if (sel_mask) mask_q <= reg_wdata[NSRC-1:0];
      if (sel_ctrl) gie_q  <= reg_wdata[0];
    end
  end

  uirq_pending #(.N(NSRC)) u_pend (
    .clk(clk), .rst(rst), .set_i(src_set), .clr_i(src_clr), .pend_o(pend)
  );

  uirq_errstat #(.N(NERR)) u_err (
    .clk(clk), .rst(rst), .cap_i(err_cap),
    .rd_clr_i(reg_rd && sel_err), .flags_o(err_flags)
  );

  uirq_out #(.N(NSRC)) u_out (
    .clk(clk), .rst(rst), .pend_i(pend), .mask_i(mask_q),
    .gie_i(gie_q), .irq_o(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_pend)      rd_mux[NSRC-1:0] = pend;
    else if (sel_mask) rd_mux[NSRC-1:0] = mask_q;
    else if (sel_ctrl) rd_mux[0]        = gie_q;
    else if (sel_err)  rd_mux[NERR-1:0] = err_flags;
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R3: reset leaves every source masked
  a_r3_reset_masked: assert property (@(posedge clk)
    rst |=> (mask_q == '1 && !gie_q));
  // R7: any error strobe sets the error pending bit
  a_r7_err_pends: assert property (@(posedge clk) disable iff (rst)
    (err_cap != '0) |=> pend[SRC_ERR]);
  // R5: a live unmasked pending source keeps the line high
  a_r5_level_held: assert property (@(posedge clk) disable iff (rst)
    (gie_q && ((pend & ~mask_q) != '0)) |=> irq);
  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, AW = 2, LW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic rx_avail = 0, modem_evt = 0;
  logic [LW-1:0] tx_level = 8'd8, tx_trig = 8'd2;
  logic err_ovr = 0, err_par = 0, err_frm = 0, err_brk = 0;
  logic irq;

  int n_checks = 0, n_fail = 0;
  logic [3:0] m_pend, m_mask, m_err;
  logic m_gie, m_irq;
  logic [DW-1:0] m_rdata;
  bit modelling = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW), .LVL_W(LW)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_avail(rx_avail), .tx_level(tx_level), .tx_trig(tx_trig),
    .modem_evt(modem_evt), .err_ovr(err_ovr), .err_par(err_par),
    .err_frm(err_frm), .err_brk(err_brk), .irq(irq)
  );

  function automatic logic [3:0] next_pend(logic [3:0] p, logic [3:0] s, logic [3:0] c);
    return (p & ~c) | s;
  endfunction

  function automatic logic [DW-1:0] read_mux(logic [AW-1:0] a);
    case (a)
      2'd0: return {4'b0, m_pend};
      2'd1: return {4'b0, m_mask};
      2'd2: return {7'b0, m_gie};
      default: return {4'b0, m_err};
    endcase
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    logic [3:0] s, c, e;
    logic nirq;
    @(posedge clk);
    if (modelling) begin
      e = {err_brk, err_frm, err_par, err_ovr};
      s = {modem_evt, (tx_level <= tx_trig), |e, rx_avail};
      c = (reg_wr && reg_addr == 2'd0) ? reg_wdata[3:0] : 4'h0;
      nirq = m_gie & |(m_pend & ~m_mask);
      if (reg_rd) m_rdata = read_mux(reg_addr);
      m_pend = next_pend(m_pend, s, c);
      m_err = ((reg_rd && reg_addr == 2'd3) ? 4'h0 : m_err) | e;
      if (reg_wr && reg_addr == 2'd1) m_mask = reg_wdata[3:0];
      if (reg_wr && reg_addr == 2'd2) m_gie = reg_wdata[0];
      m_irq = nirq;
      #2;
      check("R5 irq", {7'b0, irq}, {7'b0, m_irq});
      check("R10 rdata", reg_rdata, m_rdata);
    end else #2;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_rd = 1; reg_addr = a; tick(); reg_rd = 0; d = reg_rdata;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [DW-1:0] d;
    process::self().srandom(32'd1234);
    repeat (3) tick();
    rst = 0;
    m_pend = 0; m_mask = 4'hF; m_err = 0; m_gie = 0; m_irq = 0; m_rdata = 0;
    modelling = 1;
    tick();
    check("R4 reset irq", {7'b0, irq}, 8'h0);
    rd(2'd1, d); check("R3 reset mask", d, 8'h0F);
    rd(2'd2, d); check("R4 reset enable", d, 8'h00);
    rd(2'd0, d); check("R1 reset pend", d, 8'h00);
    // R1 modem bit 3, recorded while masked (R6)
    modem_evt = 1; tick(); modem_evt = 0;
    rd(2'd0, d); check("R1 modem bit", d, 8'h08);
    check("R3 masked quiet", {7'b0, irq}, 8'h0);
    wr(2'd1, 8'h00); tick();
    check("R4 enable off quiet", {7'b0, irq}, 8'h0);
    wr(2'd2, 8'h01); tick();
    check("R6 unmask raises", {7'b0, irq}, 8'h1);
    // R2 write zero leaves, write one clears
    wr(2'd0, 8'h00); rd(2'd0, d); check("R2 write zero keeps", d, 8'h08);
    wr(2'd0, 8'h08); rd(2'd0, d); check("R2 write one clears", d, 8'h00);
    tick(); check("R5 irq drops", {7'b0, irq}, 8'h0);
    // R9 set beats clear
    modem_evt = 1; wr(2'd0, 8'h08); modem_evt = 0;
    rd(2'd0, d); check("R9 set wins", d, 8'h08);
    wr(2'd0, 8'h0F);
    // R7 error capture
    err_ovr = 1; err_frm = 1; tick(); err_ovr = 0; err_frm = 0;
    rd(2'd0, d); check("R7 err pending", d, 8'h02);
    rd(2'd3, d); check("R7 flags", d, 8'h05);
    rd(2'd3, d); check("R8 cleared", d, 8'h00);
    err_brk = 1; tick(); err_brk = 0;
    err_par = 1; rd(2'd3, d); err_par = 0; check("R8 read returns", d, 8'h08);
    rd(2'd3, d); check("R8 capture survives", d, 8'h02);
    wr(2'd3, 8'hFF); rd(2'd3, d); check("R10 err write ignored", d, 8'h00);
    wr(2'd0, 8'h0F);
    // R1 receive and transmit bits
    rx_avail = 1; tick(); rx_avail = 0;
    tx_level = 8'd2; tick(); tx_level = 8'd3; tick(); tx_level = 8'd8;
    rd(2'd0, d); check("R1 rx tx bits", d, 8'h05);
    wr(2'd0, 8'h0F);
    // R4 turning enable off drops the line
    wr(2'd1, 8'h00); modem_evt = 1; tick(); modem_evt = 0; tick();
    check("R5 irq high", {7'b0, irq}, 8'h1);
    wr(2'd2, 8'h00); tick();
    check("R4 enable off drops", {7'b0, irq}, 8'h0);
    // Random traffic
    tx_trig = 8'd4;
    for (int i = 0; i < 4000; i++) begin
      reg_wr = ($urandom % 4) == 0;
      reg_rd = ($urandom % 3) == 0;
      reg_addr = AW'($urandom);
      reg_wdata = DW'($urandom);
      rx_avail = ($urandom % 8) == 0;
      modem_evt = ($urandom % 16) == 0;
      tx_level = LW'($urandom % 16);
      err_ovr = ($urandom % 16) == 0;
      err_par = ($urandom % 16) == 0;
      err_frm = ($urandom % 16) == 0;
      err_brk = ($urandom % 16) == 0;
      tick();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule